// File: doc/BRIEF.md
# Byte-Wide SPI Port with Mode-Fault and Write-Collision Detection

This block is an 8-bit serial port that runs either as the clock-driving master or as a slave clocked from outside. A control bit picks the role. Software reaches it through a small register interface with three registers: control, status and data. On the pin side the port has a serial clock, two data lines and an active-low select line. Each output pin comes with its own output-enable, so the surrounding pad logic can leave a pin undriven.

As a master, writing the data register starts a full-duplex exchange of eight bits, most significant bit first. The exchange runs at one of four clock rates derived from the system clock. As a slave, the port shifts under the external clock only while its select line is low. How the select line frames each byte depends on the clock phase. With phase 0 the select line must rise between bytes. With phase 1 it may stay low for a whole stream of bytes.

The port also watches for two error conditions. If another device pulls the select line low while this port is a master, the port records a mode fault and drops out of master mode. If the data register is written while a byte is in flight, the port records a write collision. A configuration input can reassign the select pin as a general-purpose output, which detaches it from the fault detector.

Top module: `spi_port_ctl`

## Requirements
- R1: After reset the control and status registers read 0 and none of the output-enables (`sck_oe`, `mosi_oe`, `miso_oe`) is asserted. The register map is: address 0 control, address 1 status, address 2 data. Control bits are: bit0 enable, bit1 master, bit2 clock idle level, bit3 clock phase, bits5:4 rate.
- R2: In master mode a data-register write sends the written byte on `mosi_out` MSB first. With phase 0, bits are sampled on the first (odd-numbered) clock edge of each bit. With phase 1, bits are sampled on the second (even-numbered) edge. The clock idles at the level given by control bit2.
- R3: Each master clock half-period lasts 1, 2, 8 or 16 system clocks for rate values 0, 1, 2 and 3, which gives division by 2, 4, 16 and 32.
- R4: When a byte finishes, status bit0 (done) is set and the byte received during that exchange can be read from the data register.
- R5: A data-register write made while a byte is in flight sets status bit1 (collision) and leaves the byte in flight unchanged.
- R6: Reading the status register while a flag is set and then accessing the data register clears the done and collision flags. For the fault flag, the step after the status read is a control-register write instead.
- R7: If the select input is low while the port is an enabled master, status bit2 (fault) is set. In the same cycle the enable and master control bits are cleared, and `sck_oe` and `mosi_oe` fall.
- R8: While `ss_gpo` is 1, a low select input neither sets the fault flag nor changes the control register.
- R9: A slave with phase 0 shifts only while selected. It presents its first bit as soon as it is selected, and its bit count restarts each time select goes high, so each byte needs its own select pulse.
- R10: A slave with phase 1 may keep select low across consecutive bytes. Each byte completes after eight bits and the next byte follows without a select pulse.
- R11: The rate bits have no effect in slave mode. A slave set to the slowest rate still exchanges bytes correctly when its clock is driven far faster than that rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives flag-clear sequencing) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Output-enable for `sck_out` |
| mosi_in | input | 1 | Data into the slave |
| mosi_out | output | 1 | Data out of the master |
| mosi_oe | output | 1 | Output-enable for `mosi_out` |
| miso_in | input | 1 | Data into the master |
| miso_out | output | 1 | Data out of the slave |
| miso_oe | output | 1 | Output-enable for `miso_out` |
| ss_n_in | input | 1 | Active-low select input |
| ss_gpo | input | 1 | 1 reassigns select as a general-purpose output and detaches its input function |

## Verification
Master exchanges run with two phase and idle-level pairs and with different byte patterns. Distinct patterns such as A5/3C and 5A/C3 show bit order and full-duplex capture, and comparing the two phases shows whether the sampling edge is chosen correctly. The slave is driven with single phase-0 bytes that each have their own select pulse, and with a phase-1 stream under a select held low. The first case tells apart a bit count that restarts on select from one that carries over. The second case shows that bytes complete without any select framing. The half-period of the three slower rates is measured directly. Fault, collision and detached-select cases are each followed through the status and control registers.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_DATA = 2'd2;

  // control register layout, bit5 down to bit0
  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // system clocks per serial-clock half-period for each rate code
  function automatic int unsigned half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    half_period = 1;
      2'd1:    half_period = 2;
      2'd2:    half_period = 8;
      default: half_period = 16;
    endcase
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_period(rate) - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              edge_evt,
  input  logic              cnt_clr,
  input  logic              cpha,
  input  logic              rx_bit,
  output logic              tx_bit,
  output logic [EDGE_W-1:0] edge_cnt,
  output logic              last_edge,
  output logic              byte_done,
  output logic [DATA_W-1:0] rx_byte
);

  logic [DATA_W-1:0] sh_q;
  logic              is_sample;

  // even edge index = leading edge; phase 0 samples there, phase 1 on trailing
  assign is_sample = (edge_cnt[0] == cpha);
  assign byte_done = edge_evt && is_sample &&
                     (edge_cnt[EDGE_W-1:1] == (EDGE_W-1)'(DATA_W - 1));
  assign last_edge = edge_evt && (edge_cnt == EDGE_W'(2 * DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      tx_bit   <= 1'b0;
      edge_cnt <= '0;
      rx_byte  <= '0;
    end else if (load) begin
      sh_q     <= load_val;
      tx_bit   <= load_val[DATA_W-1];
      edge_cnt <= '0;
    end else if (cnt_clr) begin
      edge_cnt <= '0;
      tx_bit   <= sh_q[DATA_W-1];
    end else if (edge_evt) begin
      edge_cnt <= edge_cnt + 1'b1;
      if (is_sample) begin
        sh_q <= {sh_q[DATA_W-2:0], rx_bit};
        if (byte_done) rx_byte <= {sh_q[DATA_W-2:0], rx_bit};
      end else begin
        tx_bit <= sh_q[DATA_W-1];
      end
    end
  end

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_wcol,
  input  logic set_modf,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic ctrl_wr,
  output logic done,
  output logic wcol,
  output logic modf
);

  logic arm_done, arm_wcol, arm_modf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; wcol <= 1'b0; modf <= 1'b0;
      arm_done <= 1'b0; arm_wcol <= 1'b0; arm_modf <= 1'b0;
    end else begin
      if (stat_rd) begin
        arm_done <= done;
        arm_wcol <= wcol;
        arm_modf <= modf;
      end else begin
        if (data_acc) begin arm_done <= 1'b0; arm_wcol <= 1'b0; end
        if (ctrl_wr)  arm_modf <= 1'b0;
      end
      // a set in the same cycle as a clear wins
      if (set_done)                  done <= 1'b1;
      else if (data_acc && arm_done) done <= 1'b0;
      if (set_wcol)                  wcol <= 1'b1;
      else if (data_acc && arm_wcol) wcol <= 1'b0;
      if (set_modf)                  modf <= 1'b1;
      else if (ctrl_wr && arm_modf)  modf <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe,
  input  logic              ss_n_in,
  input  logic              ss_gpo
);

  ctrl_t ctrl_q;
  logic  run_q, ph_q;
  logic  sck_s, sck_d, ss_s, mosi_s;

  // named internal events
  logic master_on, slave_on, selected;
  logic ctrl_wr, data_wr, stat_rd, data_acc;
  logic busy, slave_busy, wcol_evt, modf_evt, start, slave_load;
  logic tick, edge_evt, cnt_clr, rx_bit;
  logic tx_bit, last_edge, byte_done, xfer_done;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DATA_W-1:0] rx_byte;
  logic flag_done, flag_wcol, flag_modf;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:CTRL_W];

  assign selected   = !ss_gpo && !ss_s;
  assign master_on  = ctrl_q.en && ctrl_q.master;
  assign slave_on   = ctrl_q.en && !ctrl_q.master && selected;
  assign modf_evt   = master_on && selected;

  assign ctrl_wr    = wr_en && (addr == ADR_CTRL);
  assign data_wr    = wr_en && (addr == ADR_DATA);
  assign stat_rd    = rd_en && (addr == ADR_STAT);
  assign data_acc   = (wr_en || rd_en) && (addr == ADR_DATA);

  assign slave_busy = slave_on && (edge_cnt != '0);
  assign busy       = run_q || slave_busy;
  assign wcol_evt   = data_wr && busy;
  assign start      = data_wr && !busy && master_on && !modf_evt;
  assign slave_load = data_wr && !busy && ctrl_q.en && !ctrl_q.master;

  assign edge_evt   = master_on ? (run_q && tick) : (slave_on && (sck_s ^ sck_d));
  assign cnt_clr    = !run_q && !slave_on;
  assign rx_bit     = master_on ? miso_in : mosi_s;
  assign xfer_done  = master_on ? (run_q && last_edge) : (slave_on && byte_done);

  spi_rate_gen #(.CNT_W(DIV_W)) u_rate (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .rate (ctrl_q.rate),
    .tick (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start || slave_load),
    .load_val (wdata),
    .edge_evt (edge_evt),
    .cnt_clr  (cnt_clr),
    .cpha     (ctrl_q.cpha),
    .rx_bit   (rx_bit),
    .tx_bit   (tx_bit),
    .edge_cnt (edge_cnt),
    .last_edge(last_edge),
    .byte_done(byte_done),
    .rx_byte  (rx_byte)
  );

  spi_flag_unit u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_done(xfer_done),
    .set_wcol(wcol_evt),
    .set_modf(modf_evt),
    .stat_rd (stat_rd),
    .data_acc(data_acc),
    .ctrl_wr (ctrl_wr),
    .done    (flag_done),
    .wcol    (flag_wcol),
    .modf    (flag_modf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      sck_s  <= 1'b0;
      sck_d  <= 1'b0;
      ss_s   <= 1'b1;
      mosi_s <= 1'b0;
    end else begin
      sck_s  <= sck_in;
      sck_d  <= sck_s;
      ss_s   <= ss_n_in;
      mosi_s <= mosi_in;
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (modf_evt) begin
        ctrl_q.en     <= 1'b0;
        ctrl_q.master <= 1'b0;
      end
      if (modf_evt || !master_on) begin
        run_q <= 1'b0;
        ph_q  <= 1'b0;
      end else if (start) begin
        run_q <= 1'b1;
        ph_q  <= 1'b0;
      end else if (edge_evt) begin
        ph_q <= ~ph_q;
        if (last_edge) run_q <= 1'b0;
      end
    end
  end

  assign sck_out  = ctrl_q.cpol ^ ph_q;
  assign sck_oe   = master_on;
  assign mosi_out = tx_bit;
  assign mosi_oe  = master_on;
  assign miso_out = tx_bit;
  assign miso_oe  = slave_on;

  always_comb begin
    case (addr)
      ADR_CTRL: rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      ADR_STAT: rdata = {{(DATA_W-3){1'b0}}, flag_modf, flag_wcol, flag_done};
      ADR_DATA: rdata = rx_byte;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ctrl_en,
  input logic ctrl_master,
  input logic flag_done,
  input logic flag_wcol,
  input logic flag_modf,
  input logic ss_gpo,
  input logic busy,
  input logic data_wr,
  input logic xfer_done,
  input logic sck_oe,
  input logic mosi_oe,
  input logic miso_oe
);

  a_r7_fault_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_modf) |-> (!ctrl_en && !ctrl_master && !sck_oe && !mosi_oe));

  a_r8_detached_select_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_gpo && !flag_modf) |=> !flag_modf);

  a_r5_busy_write_collides: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> flag_wcol);

  a_r4_completion_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> flag_done);

  a_r1_disabled_releases_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (!sck_oe && !mosi_oe && !miso_oe));

endmodule

bind spi_port_ctl spi_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_en    (ctrl_q.en),
  .ctrl_master(ctrl_q.master),
  .flag_done  (flag_done),
  .flag_wcol  (flag_wcol),
  .flag_modf  (flag_modf),
  .ss_gpo     (ss_gpo),
  .busy       (busy),
  .data_wr    (data_wr),
  .xfer_done  (xfer_done),
  .sck_oe     (sck_oe),
  .mosi_oe    (mosi_oe),
  .miso_oe    (miso_oe)
);

// File: tb/spi_port_ctl_tb.sv
module spi_port_ctl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck_in = 1'b0, mosi_in = 1'b0, miso_in = 1'b0;
  logic       ss_n_in = 1'b1, ss_gpo = 1'b0;
  logic       sck_out, sck_oe, mosi_out, mosi_oe, miso_out, miso_oe;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_port_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck_in(sck_in), .sck_out(sck_out),
    .sck_oe(sck_oe), .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
    .ss_n_in(ss_n_in), .ss_gpo(ss_gpo)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_done(output logic [7:0] st);
    int guard = 0;
    st = '0;
    while (!st[0] && guard < 3000) begin
      reg_rd(2'd1, st);
      guard++;
    end
  endtask

  // scoreboard state: expected master output bytes and a slave model
  logic [7:0] exp_q[$];
  bit         mon_on = 0;
  logic       cur_cpha = 1'b0;
  logic       m_prev = 1'b0;
  int         m_cnt = 0, m_bits = 0, ml_launch = 0;
  logic [7:0] m_sh = '0, sl_byte = '0;

  // monitor: follows master clock edges, samples MOSI, drives MISO
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && sck_out !== m_prev) begin
        m_prev = sck_out;
        if ((m_cnt % 2) == int'(cur_cpha)) begin
          m_sh = {m_sh[6:0], mosi_out};
          m_bits++;
          if (m_bits == 8) begin
            if (exp_q.size() == 0) check("R2 unexpected byte", m_sh, 8'hxx);
            else check("R2 mosi byte", m_sh, exp_q.pop_front());
          end
        end else if (ml_launch < 8) begin
          miso_in = sl_byte[7 - ml_launch];
          ml_launch++;
        end
        m_cnt = (m_cnt + 1) % 16;
      end
    end
  end

  // driver: configures master, queues expected byte, optionally collides
  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] slv,
                             input logic cpol, input logic cpha,
                             input logic [1:0] rate, input bit collide);
    logic [7:0] st, rx;
    cur_cpha = cpha; sl_byte = slv; miso_in = slv[7];
    ml_launch = cpha ? 0 : 1; m_bits = 0; m_cnt = 0;
    reg_wr(2'd0, {2'b00, rate, cpha, cpol, 1'b1, 1'b1});
    m_prev = sck_out;
    check("R2 idle clock level", {7'd0, sck_out}, {7'd0, cpol});
    mon_on = 1;
    exp_q.push_back(tx);
    reg_wr(2'd2, tx);
    if (collide) begin
      repeat (3) @(negedge clk);
      reg_wr(2'd2, ~tx);
    end
    wait_done(st);
    mon_on = 0;
    check(collide ? "R5 status done+collision" : "R4 status done",
          st, collide ? 8'h03 : 8'h01);
    reg_rd(2'd2, rx);
    check("R4 received byte", rx, slv);
    reg_rd(2'd1, st);
    check("R6 flags cleared after data read", st, 8'h00);
  endtask

  task automatic measure_half(input logic [1:0] rate, input int exp);
    logic [7:0] st, rx;
    int n = 0;
    logic idle;
    reg_wr(2'd0, {2'b00, rate, 1'b1, 1'b0, 1'b1, 1'b1});
    idle = sck_out;
    reg_wr(2'd2, 8'h81);
    while (sck_out === idle && n < 100) begin @(negedge clk); n++; end
    n = 0;
    while (sck_out !== idle && n < 100) begin @(negedge clk); n++; end
    check("R3 half period", 8'(n), 8'(exp));
    wait_done(st);
    reg_rd(2'd2, rx);
  endtask

  localparam int HB = 3;

  // bench acts as external master for the slave port
  task automatic slave_xfer(input logic cpha, input logic [1:0] rate,
                            input logic [7:0] din, input logic [7:0] dexp,
                            input bit hold, input string req);
    logic [7:0] got = '0, st, rx;
    reg_wr(2'd0, {2'b00, rate, cpha, 1'b0, 1'b0, 1'b1});
    reg_wr(2'd2, dexp);
    repeat (3) @(negedge clk);
    if (!cpha) mosi_in = din[7];
    if (ss_n_in) begin ss_n_in = 1'b0; repeat (4) @(negedge clk); end
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        repeat (HB) @(negedge clk);
        got[7-i] = miso_out;
        sck_in = 1'b1;
        repeat (HB) @(negedge clk);
        sck_in = 1'b0;
        if (i < 7) mosi_in = din[6-i];
      end else begin
        sck_in = 1'b1;
        mosi_in = din[7-i];
        repeat (HB) @(negedge clk);
        got[7-i] = miso_out;
        sck_in = 1'b0;
        repeat (HB) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    if (!hold) begin ss_n_in = 1'b1; repeat (4) @(negedge clk); end
    check({req, " miso byte"}, got, dexp);
    reg_rd(2'd1, st);
    check({req, " done"}, st, 8'h01);
    reg_rd(2'd2, rx);
    check({req, " received"}, rx, din);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    reg_rd(2'd0, v); check("R1 control after reset", v, 8'h00);
    reg_rd(2'd1, v); check("R1 status after reset", v, 8'h00);
    check("R1 output enables", {5'd0, sck_oe, mosi_oe, miso_oe}, 8'h00);

    // R2/R4 master exchanges with two phase/polarity combinations
    master_xfer(8'hA5, 8'h3C, 1'b0, 1'b0, 2'd0, 0);
    master_xfer(8'h5A, 8'hC3, 1'b1, 1'b1, 2'd1, 0);
    master_xfer(8'h01, 8'h80, 1'b0, 1'b1, 2'd0, 0);

    // R3 rate divider
    measure_half(2'd1, 2);
    measure_half(2'd2, 8);
    measure_half(2'd3, 16);

    // R5 collision during a slow transfer, byte in flight unchanged
    master_xfer(8'h96, 8'h69, 1'b0, 1'b0, 2'd2, 1);

    // R7 mode fault
    reg_wr(2'd0, 8'h03);
    ss_n_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 pins released", {6'd0, sck_oe, mosi_oe}, 8'h00);
    reg_rd(2'd1, v); check("R7 fault flag", v, 8'h04);
    reg_rd(2'd0, v); check("R7 enable and master cleared", v, 8'h00);
    ss_n_in = 1'b1;
    repeat (3) @(negedge clk);
    reg_rd(2'd1, v);
    reg_wr(2'd0, 8'h00);
    reg_rd(2'd1, v); check("R6 fault flag cleared by control write", v, 8'h00);

    // R8 detached select input
    ss_gpo = 1'b1;
    reg_wr(2'd0, 8'h03);
    ss_n_in = 1'b0;
    repeat (5) @(negedge clk);
    reg_rd(2'd1, v); check("R8 no fault flag", v, 8'h00);
    reg_rd(2'd0, v); check("R8 control unchanged", v, 8'h03);
    check("R8 clock still driven", {7'd0, sck_oe}, 8'h01);
    ss_n_in = 1'b1;
    reg_wr(2'd0, 8'h00);
    ss_gpo = 1'b0;
    repeat (3) @(negedge clk);

    // R9 slave phase 0, select pulsed per byte
    slave_xfer(1'b0, 2'd0, 8'hB4, 8'h2D, 0, "R9 byte1");
    slave_xfer(1'b0, 2'd0, 8'h4B, 8'hD2, 0, "R9 byte2");

    // R10/R11 slave phase 1, select held low, slowest rate code set
    slave_xfer(1'b1, 2'd3, 8'hE1, 8'h1E, 1, "R10 R11 byte1");
    slave_xfer(1'b1, 2'd3, 8'h77, 8'h88, 1, "R10 R11 byte2");
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);

    check("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule